// File: doc/BRIEF.md
# Ping-Pong Parameter Bank Loader

This block accepts per-row parameter bursts from a host over three wires: serial data, serial clock and a stream reset. It stores each received bit into one of two single-bit-wide parameter banks. The other bank stays frozen, so a playback engine can read it through a simple read port. The host first pulses the stream reset. It then clocks in the first frame's bits, then the next frame's, one bit per serial clock rising edge. An internal address counter places each bit at the next location.

Bank roles are exchanged, not copied. A level taken from a line counter bit (the bit that flips every 64 lines) is watched for changes. Each change, in either direction, swaps which bank is written and which is read. The bank that was just filled becomes the playback bank, and the previous playback bank is overwritten by the next burst. All host inputs and the line bit are asynchronous to `clk` and are synchronized inside the block.

The receive controller is a two-state machine. WAIT is entered at reset, and in WAIT serial clock edges are ignored. The transition WAIT→RECV is taken on a stream reset edge. In RECV, the transition RECV→RECV (restart) is taken on a stream reset edge and clears the address. In RECV, the transition RECV→RECV (store) is taken on a serial clock edge and writes one bit, then advances the address.

Top module: `pingpong_param_loader`

## Requirements
- R1: After reset the read bank is bank 0 (`rd_bank` = 0), the write bank is bank 1, the controller is in WAIT and the write address is 0.
- R2: Serial clock rising edges that arrive before the first stream reset rising edge store nothing and do not advance the write address.
- R3: A stream reset rising edge returns the write address to 0, including in the middle of a burst; later bits overwrite from address 0.
- R4: In RECV, each serial clock rising edge stores the sampled serial data bit at the current write address of the write bank, and the address then advances by one.
- R5: The write address is ADDR_W bits wide and wraps from 2^ADDR_W−1 to 0.
- R6: Each change of the line band bit, rising or falling, swaps the bank roles and toggles `rd_bank`. With no change, `rd_bank` holds.
- R7: No bit is ever written into the bank currently selected for reading; the read bank's contents stay unchanged while the other bank is loaded.
- R8: `rd_data` shows, one `clk` cycle after `rd_addr` is applied, the bit stored at that address of the bank named by `rd_bank`.
- R9: When a serial clock edge and a line band change are recognized in the same cycle, the bit is stored in the pre-swap write bank, which then becomes the read bank.
- R10: When a stream reset edge and a serial clock edge are recognized in the same cycle, the bit is discarded and the address becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sclk | input | 1 | Host serial clock; rising edge delivers one bit |
| host_sdata | input | 1 | Host serial data, stable around the serial clock rise |
| host_srst | input | 1 | Host stream reset; rising edge restarts the address |
| line_band_bit | input | 1 | Line counter bit whose every change swaps bank roles |
| rd_addr | input | ADDR_W | Playback read address |
| rd_data | output | 1 | Registered read data from the read bank |
| rd_bank | output | 1 | Index of the bank currently selected for reading |

## Verification
Two functions can coincide in one cycle. A bank swap can meet a bit store, and a stream restart can meet a bit store. Both are provoked by changing the two asynchronous inputs at the same instant; the equal-length synchronizers then present both edges in the same `clk` cycle. In the swap case, the bench reads the new read bank at that address and expects the coincident bit there. In the restart case, it expects the discarded bit to be missing, and the next two bits to sit at addresses 0 and 1 with address 2 untouched.

// File: rtl/ppl_pkg.sv
package ppl_pkg;

    // Receive controller states
    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,   // no stream reset seen yet, serial clocks ignored
        ST_RECV = 1'b1    // accepting bits into the write bank
    } rx_state_t;

    // Synchronizer output flavours
    typedef enum logic [1:0] {
        SYNC_LEVEL = 2'd0,  // delayed level only
        SYNC_RISE  = 2'd1,  // one-cycle pulse on a rising edge
        SYNC_ANY   = 2'd2   // one-cycle pulse on any change
    } sync_mode_t;

endpackage

// File: rtl/ppl_edge_sync.sv
module ppl_edge_sync #(
    parameter int                  STAGES = 2,
    parameter ppl_pkg::sync_mode_t MODE   = ppl_pkg::SYNC_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sig_o
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    generate
        if (MODE == ppl_pkg::SYNC_LEVEL) begin : g_level
            assign sig_o = chain[STAGES-1];
        end else begin : g_edge
            logic last_q;
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= 1'b0;
                else        last_q <= chain[STAGES-1];
            end
            if (MODE == ppl_pkg::SYNC_ANY) begin : g_any
                assign sig_o = chain[STAGES-1] ^ last_q;
            end else begin : g_rise
                assign sig_o = chain[STAGES-1] & ~last_q;
            end
        end
    endgenerate

endmodule

// File: rtl/ppl_wr_ctrl.sv
module ppl_wr_ctrl #(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart_i,
    input  logic                tick_i,
    input  logic                data_i,
    input  logic                swap_i,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic                wr_bit_o,
    output logic                wr_bank_o,
    output ppl_pkg::rx_state_t  state_o
);
    import ppl_pkg::*;

    rx_state_t         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              bank_q;
    logic              store;

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            addr_q  <= '0;
            bank_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (restart_i)  addr_q <= '0;
            else if (store) addr_q <= addr_q + 1'b1;
            if (swap_i) bank_q <= ~bank_q;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        store   = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (restart_i) state_d = ST_RECV;
            end
            ST_RECV: begin
                state_d = ST_RECV;
                store   = tick_i && !restart_i;
            end
        endcase
    end

    assign wr_en_o   = store;
    assign wr_addr_o = addr_q;
    assign wr_bit_o  = data_i;
    assign wr_bank_o = bank_q;
    assign state_o   = state_q;

endmodule

// File: rtl/ppl_bank_role.sv
module ppl_bank_role (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    output logic rd_bank_o
);

    logic rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= 1'b0;
        else if (swap_i) rd_q <= ~rd_q;
    end

    assign rd_bank_o = rd_q;

endmodule

// File: rtl/ppl_bank_pair.sv
module ppl_bank_pair #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic              wr_bank_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              wr_bit_i,
    input  logic              rd_bank_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_data_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NBANKS = 2;

    logic [NBANKS-1:0] bank_word;

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            logic mem [DEPTH];
            always_ff @(posedge clk) begin
                if (wr_en_i && (wr_bank_i == 1'(b))) mem[wr_addr_i] <= wr_bit_i;
            end
            assign bank_word[b] = mem[rd_addr_i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        rd_data_o <= bank_word[rd_bank_i];
    end

endmodule

// File: rtl/pingpong_param_loader.sv
module pingpong_param_loader #(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_sdata,
    input  logic              host_srst,
    input  logic              line_band_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_data,
    output logic              rd_bank
);
    import ppl_pkg::*;

    logic              tick_p, restart_p, swap_p, data_s;
    logic              wr_en, wr_bit, wr_bank;
    logic [ADDR_W-1:0] wr_addr;
    rx_state_t         rx_state;

    ppl_edge_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_i(host_sclk), .sig_o(tick_p));

    ppl_edge_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_RISE)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .async_i(host_srst), .sig_o(restart_p));

    ppl_edge_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_LEVEL)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .async_i(host_sdata), .sig_o(data_s));

    ppl_edge_sync #(.STAGES(SYNC_STAGES), .MODE(SYNC_ANY)) u_sync_band (
        .clk(clk), .rst_n(rst_n), .async_i(line_band_bit), .sig_o(swap_p));

    ppl_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .restart_i(restart_p), .tick_i(tick_p), .data_i(data_s), .swap_i(swap_p),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_bit_o(wr_bit),
        .wr_bank_o(wr_bank), .state_o(rx_state));

    ppl_bank_role u_role (
        .clk(clk), .rst_n(rst_n), .swap_i(swap_p), .rd_bank_o(rd_bank));

    ppl_bank_pair #(.ADDR_W(ADDR_W)) u_banks (
        .clk(clk),
        .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_addr_i(wr_addr), .wr_bit_i(wr_bit),
        .rd_bank_i(rd_bank), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

endmodule

// File: rtl/ppl_checker.sv
module ppl_checker #(
    parameter int ADDR_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               restart_p,
    input logic               swap_p,
    input logic               wr_en,
    input logic               wr_bank,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic               rd_bank,
    input ppl_pkg::rx_state_t rx_state
);
    import ppl_pkg::*;

    p_wait_no_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == ST_WAIT) |-> !wr_en);

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart_p |=> (wr_addr == '0));

    // also covers the wrap of R5
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    p_swap_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_p |=> (rd_bank != $past(rd_bank)));

    p_band_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_p |=> $stable(rd_bank));

    p_no_read_bank_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != rd_bank));

endmodule

bind pingpong_param_loader ppl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .restart_p(restart_p), .swap_p(swap_p),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .rd_bank(rd_bank), .rx_state(rx_state));

// File: tb/tb_pingpong_param_loader.sv
module tb_pingpong_param_loader;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0, sdata = 1'b0, srst = 1'b0, band = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_data, rd_bank;

    always #5 clk = ~clk;

    pingpong_param_loader #(.ADDR_W(AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .host_sclk(sclk), .host_sdata(sdata),
        .host_srst(srst), .line_band_bit(band), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_bank(rd_bank));

    int checks = 0, errors = 0;
    bit done = 0;

    // Reference model built from the requirements
    bit mdl [2][DEPTH];
    int m_wb = 1, m_rb = 0, m_addr = 0;
    bit m_run = 0;

    typedef struct { int addr; bit val; string tag; } rd_item_t;
    rd_item_t sb[$];

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk); sdata = b; wait_n(3);
        sclk = 1'b1; wait_n(3);
        sclk = 1'b0;
        if (m_run) begin
            mdl[m_wb][m_addr] = b;
            m_addr = (m_addr + 1) % DEPTH;
        end
    endtask

    task automatic stream_reset();
        @(negedge clk); srst = 1'b1; wait_n(3);
        srst = 1'b0; wait_n(3);
        m_run = 1; m_addr = 0;
    endtask

    task automatic band_flip();
        @(negedge clk); band = ~band; wait_n(6);
        m_wb = 1 - m_wb; m_rb = 1 - m_rb;
    endtask

    // Driver: pushes expected read results to the scoreboard
    task automatic rd_expect(input int a, input string tag);
        rd_item_t it;
        @(negedge clk);
        rd_addr = AW'(a);
        it.addr = a; it.val = mdl[m_rb][a]; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares registered read data one cycle after the address
    initial begin
        rd_item_t it;
        forever begin
            @(posedge clk); #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.val) begin
                    errors++;
                    $display("FAIL %s: addr=%0d actual=%0d expected=%0d",
                             it.tag, it.addr, rd_data, it.val);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        wait_n(150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit c_bit;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(rd_bank, 0, "R1 read bank after reset");

        // R2: bits before any stream reset are dropped
        send_bit(1); send_bit(1); send_bit(1);
        chk(rd_bank, 0, "R2 no role change from ignored bits");

        // R4: burst A into bank 1
        stream_reset();
        for (int i = 0; i < 40; i++) send_bit(bit'(((i * 7 + 4) % 5) < 2));
        band_flip();
        chk(rd_bank, 1, "R6 swap on rising band bit");
        for (int i = 0; i < 40; i++) rd_expect(i, "R4/R2 burst A readback");

        // R7: load bank 0 while bank 1 is read
        stream_reset();
        for (int i = 0; i < 30; i++) send_bit(bit'(i[0] ^ i[2]));
        for (int i = 0; i < 40; i++) rd_expect(i, "R7 read bank untouched");

        // R3: restart mid-burst, short burst C
        stream_reset();
        for (int i = 0; i < 10; i++) send_bit(bit'(~(i[0] ^ i[2])));
        band_flip();
        chk(rd_bank, 0, "R6 swap on falling band bit");
        for (int i = 0; i < 30; i++) rd_expect(i, "R3/R8 restart overwrite");

        // R9: serial clock edge coincides with band change
        stream_reset();
        send_bit(0); send_bit(0);
        @(negedge clk); sdata = 1'b1; wait_n(3);
        sclk = 1'b1; band = ~band; wait_n(3);
        sclk = 1'b0; wait_n(4);
        mdl[m_wb][m_addr] = 1'b1; m_addr++;
        m_wb = 1 - m_wb; m_rb = 1 - m_rb;
        chk(rd_bank, 1, "R9 roles swapped");
        for (int i = 0; i < 3; i++) rd_expect(i, "R9 coincident bit in pre-swap bank");

        // R10: stream reset coincides with a serial clock edge
        @(negedge clk); sdata = 1'b0; wait_n(3);
        srst = 1'b1; sclk = 1'b1; wait_n(3);
        srst = 1'b0; sclk = 1'b0; wait_n(3);
        m_addr = 0;
        send_bit(1); send_bit(1);
        band_flip();
        chk(rd_bank, 0, "R10 swap for readback");
        for (int i = 0; i < 3; i++) rd_expect(i, "R10 coincident bit discarded");

        // R5: wrap of the write address
        stream_reset();
        for (int i = 0; i < DEPTH; i++) send_bit(bit'(i[0] ^ i[3]));
        send_bit(1); send_bit(0); send_bit(1);
        band_flip();
        chk(rd_bank, 1, "R5 swap for readback");
        for (int i = 0; i < 5; i++) rd_expect(i, "R5 wrapped writes");
        rd_expect(DEPTH - 1, "R5 top address");
        rd_expect(DEPTH - 2, "R5 near top address");

        wait_n(4);
        chk(sb.size(), 0, "R8 scoreboard drained");
        finish_run();
    end

endmodule